// File: doc/BRIEF.md
# Clock Source Select Controller

This block chooses the machine clock source and holds the register that software uses to control it. It runs on the main oscillator clock. A single counter times three kinds of wait. The first is a fixed wait after power-on. The second is a programmable oscillator-settling wait after the chip leaves stop or standby. The third is a fixed PLL lock wait that runs whenever software asks for the PLL. The analog PLL, the oscillator and the glitch-free clock switch sit outside this block. The switch reads `use_pll`, and the PLL reads `pll_mult`.

Software writes one 8-bit control byte. It asks for the PLL by clearing the select bit. The read-only status bit keeps reporting the main clock until the lock wait has run its full length, and only then does it report the PLL. Setting the select bit again returns the machine clock to the main clock on the next cycle and drops any lock wait still in progress. While any wait runs, `busy` is high and the machine clock stays on the main source.

The byte is laid out as follows:

| Bit | Field |
|-----|-------|
| 7 | reserved, reads 1 |
| 6 | status: 1 = main clock, 0 = PLL |
| 5:4 | oscillator wait code |
| 3 | reserved, reads 1 |
| 2 | select: 1 = main, 0 = PLL requested |
| 1:0 | PLL multiplier code |

Both resets are synchronous and active high.

Top module: `clksel_ctrl`

## Requirements
- R1: While `por` is high, select and status are set to 1, the multiplier code is set to 00, the wait code is set to 11, and `rd_data` reads 8'hFC.
- R2: A general reset (`rst` high with `por` low) sets select and status to 1, sets the multiplier code to 00, ends any wait so that `busy` drops, and leaves the wait code unchanged.
- R3: Status (bit 6) is read-only, and writes to bits 6, 7 and 3 have no effect. Bits 7 and 3 always read 1.
- R4: A write that clears select while status is 1 starts a PLL lock wait on the next clock edge. `busy` then stays high for exactly 2^PLL_LOG2 cycles, after which status reads 0 and `use_pll` goes high.
- R5: After the last cycle with `por` high, `busy` stays high for exactly 2^POR_LOG2 cycles.
- R6: A `wake` pulse starts an oscillator wait whose length is set by the wait code: 00 gives 2^WS0_LOG2 cycles, 01 gives 2^WS1_LOG2, 10 gives 2^WS2_LOG2 and 11 gives 2^WS3_LOG2. A new pulse restarts a running oscillator wait. A pulse during the power-on wait is ignored.
- R7: A write that sets select makes status 1 and `use_pll` 0 at the same edge, and cancels a PLL lock wait in progress.
- R8: `use_pll` is low whenever `busy` is high.
- R9: A write to the wait code while a wait is running changes only the length of later waits.
- R10: The multiplier code is read and written at bits 1:0 and drives `pll_mult` directly.
- R11: If a PLL request is pending when an oscillator or power-on wait ends, the lock wait follows with no idle cycle, so `busy` stays high throughout.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Main oscillator clock |
| por | input | 1 | Power-on reset, synchronous, active high |
| rst | input | 1 | General reset, synchronous, active high |
| wake | input | 1 | One-cycle pulse marking release from stop or standby |
| wr_en | input | 1 | Write strobe for the control byte |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Control byte read value |
| use_pll | output | 1 | 1 when the machine clock should come from the PLL |
| busy | output | 1 | A stabilization wait is running |
| pll_mult | output | 2 | PLL multiplier code |

## Verification
The bench counts the exact width of every `busy` window against the requirement lengths. An off-by-one load or decrement in the counter would show up as a window one cycle too long or too short. It cancels a lock wait part-way through and then watches for a late switch to the PLL, which is what a design that only masked the wait would do. It also writes the wait code during a running wait: a design that decoded the length live would stretch the current window. A further check chains an oscillator wait into a lock wait and looks for the idle gap a naive sequencer leaves between them. Finally, it sends `wake` during the power-on wait, where a design lacking the guard would restart the wait at the oscillator length.

// File: rtl/clksel_pkg.sv
package clksel_pkg;

    typedef enum logic [1:0] {
        WK_IDLE = 2'd0,
        WK_POR  = 2'd1,
        WK_OSC  = 2'd2,
        WK_PLL  = 2'd3
    } wait_kind_e;

    typedef struct packed {
        logic       sel;
        logic       stat;
        logic [1:0] ws;
        logic [1:0] mult;
    } ctl_t;

    localparam int RSV_HI_BIT = 7;
    localparam int STAT_BIT   = 6;
    localparam int WS_HI_BIT  = 5;
    localparam int WS_LO_BIT  = 4;
    localparam int RSV_LO_BIT = 3;
    localparam int SEL_BIT    = 2;
    localparam int MULT_HI    = 1;

    function automatic int max2(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/clksel_lendec.sv
module clksel_lendec #(
    parameter int CNT_W = 19,
    parameter int L0    = 10,
    parameter int L1    = 13,
    parameter int L2    = 15,
    parameter int L3    = 17
) (
    input  logic [1:0]       code,
    output logic [CNT_W-1:0] len
);
    localparam logic [CNT_W-1:0] LEN0 = CNT_W'(1) << L0;
    localparam logic [CNT_W-1:0] LEN1 = CNT_W'(1) << L1;
    localparam logic [CNT_W-1:0] LEN2 = CNT_W'(1) << L2;
    localparam logic [CNT_W-1:0] LEN3 = CNT_W'(1) << L3;

    always_comb begin
        case (code)
            2'b00:   len = LEN0;
            2'b01:   len = LEN1;
            2'b10:   len = LEN2;
            default: len = LEN3;
        endcase
    end
endmodule

// File: rtl/clksel_regs.sv
module clksel_regs
    import clksel_pkg::*;
(
    input  logic       clk,
    input  logic       por,
    input  logic       rst,
    input  logic       wr_en,
    input  logic [7:0] wr_data,
    input  logic       pll_done,
    output ctl_t       ctl,
    output logic       wr_main
);
    ctl_t ctl_d, ctl_q;

    always_comb begin
        wr_main = wr_en && wr_data[SEL_BIT];
        ctl_d   = ctl_q;
        if (por) begin
            ctl_d.sel  = 1'b1;
            ctl_d.stat = 1'b1;
            ctl_d.ws   = 2'b11;
            ctl_d.mult = 2'b00;
        end else if (rst) begin
            ctl_d.sel  = 1'b1;
            ctl_d.stat = 1'b1;
            ctl_d.mult = 2'b00;
        end else begin
            if (wr_en) begin
                ctl_d.sel  = wr_data[SEL_BIT];
                ctl_d.ws   = wr_data[WS_HI_BIT:WS_LO_BIT];
                ctl_d.mult = wr_data[MULT_HI:0];
            end
            if (wr_main) begin
                ctl_d.stat = 1'b1;
            end else if (pll_done && !ctl_q.sel) begin
                ctl_d.stat = 1'b0;
            end
        end
    end

    always_ff @(posedge clk) begin
        ctl_q <= ctl_d;
    end

    assign ctl = ctl_q;

    // R3 / R7: the main clock is reported whenever the main source is selected
    assert_sel_implies_main_R7: assert property (@(posedge clk) disable iff (por || rst)
        ctl_q.sel |-> ctl_q.stat);

    // R4: status leaves the main clock only at the end of a lock wait
    assert_stat_falls_on_lock_R4: assert property (@(posedge clk) disable iff (por || rst)
        $fell(ctl_q.stat) |-> $past(pll_done));

    // R2: a general reset keeps the wait code
    assert_ws_kept_on_reset_R2: assert property (@(posedge clk) disable iff (por)
        rst |=> (ctl_q.ws == $past(ctl_q.ws)));
endmodule

// File: rtl/clksel_timer.sv
module clksel_timer
    import clksel_pkg::*;
#(
    parameter int CNT_W    = 19,
    parameter int PLL_LOG2 = 13,
    parameter int POR_LOG2 = 18
) (
    input  logic             clk,
    input  logic             por,
    input  logic             rst,
    input  logic             wake,
    input  logic             pll_req,
    input  logic             cancel,
    input  logic [CNT_W-1:0] osc_len,
    output logic             busy,
    output logic             pll_done
);
    localparam logic [CNT_W-1:0] PLL_LEN = CNT_W'(1) << PLL_LOG2;
    localparam logic [CNT_W-1:0] POR_LEN = CNT_W'(1) << POR_LOG2;

    typedef struct packed {
        wait_kind_e       kind;
        logic [CNT_W-1:0] cnt;
    } tmr_t;

    tmr_t t_d, t_q;
    logic last_q;

    assign last_q = (t_q.cnt == CNT_W'(1));

    always_comb begin
        t_d = t_q;
        if (por) begin
            t_d.kind = WK_POR;
            t_d.cnt  = POR_LEN;
        end else if (rst) begin
            t_d.kind = WK_IDLE;
            t_d.cnt  = '0;
        end else if (wake && t_q.kind != WK_POR) begin
            t_d.kind = WK_OSC;
            t_d.cnt  = osc_len;
        end else if (t_q.kind == WK_PLL && cancel) begin
            t_d.kind = WK_IDLE;
            t_d.cnt  = '0;
        end else if (t_q.kind != WK_IDLE) begin
            if (last_q) begin
                if (t_q.kind != WK_PLL && pll_req && !cancel) begin
                    t_d.kind = WK_PLL;
                    t_d.cnt  = PLL_LEN;
                end else begin
                    t_d.kind = WK_IDLE;
                    t_d.cnt  = '0;
                end
            end else begin
                t_d.cnt = t_q.cnt - CNT_W'(1);
            end
        end else if (pll_req && !cancel) begin
            t_d.kind = WK_PLL;
            t_d.cnt  = PLL_LEN;
        end
    end

    always_ff @(posedge clk) begin
        t_q <= t_d;
    end

    assign busy     = (t_q.kind != WK_IDLE);
    assign pll_done = (t_q.kind == WK_PLL) && last_q;

    // R5 / R6: a running wait never holds an empty count
    assert_count_live_R6: assert property (@(posedge clk) disable iff (por || rst)
        (t_q.kind != WK_IDLE) |-> (t_q.cnt != '0));

    // R4: a lock wait runs only while the request stands
    assert_lock_needs_request_R4: assert property (@(posedge clk) disable iff (por || rst)
        (t_q.kind == WK_PLL) |-> pll_req);
endmodule

// File: rtl/clksel_ctrl.sv
module clksel_ctrl
    import clksel_pkg::*;
#(
    parameter int PLL_LOG2  = 13,
    parameter int POR_LOG2  = 18,
    parameter int WS0_LOG2  = 10,
    parameter int WS1_LOG2  = 13,
    parameter int WS2_LOG2  = 15,
    parameter int WS3_LOG2  = 17
) (
    input  logic       clk,
    input  logic       por,
    input  logic       rst,
    input  logic       wake,
    input  logic       wr_en,
    input  logic [7:0] wr_data,
    output logic [7:0] rd_data,
    output logic       use_pll,
    output logic       busy,
    output logic [1:0] pll_mult
);
    localparam int MAX_LOG2 = max2(max2(max2(PLL_LOG2, POR_LOG2), max2(WS0_LOG2, WS1_LOG2)),
                                   max2(WS2_LOG2, WS3_LOG2));
    localparam int CNT_W    = MAX_LOG2 + 1;

    ctl_t             ctl;
    logic             wr_main;
    logic             pll_done;
    logic             pll_req;
    logic [CNT_W-1:0] osc_len;

    clksel_regs u_regs (
        .clk      (clk),
        .por      (por),
        .rst      (rst),
        .wr_en    (wr_en),
        .wr_data  (wr_data),
        .pll_done (pll_done),
        .ctl      (ctl),
        .wr_main  (wr_main)
    );

    clksel_lendec #(
        .CNT_W (CNT_W),
        .L0    (WS0_LOG2),
        .L1    (WS1_LOG2),
        .L2    (WS2_LOG2),
        .L3    (WS3_LOG2)
    ) u_lendec (
        .code (ctl.ws),
        .len  (osc_len)
    );

    assign pll_req = !ctl.sel && ctl.stat;

    clksel_timer #(
        .CNT_W    (CNT_W),
        .PLL_LOG2 (PLL_LOG2),
        .POR_LOG2 (POR_LOG2)
    ) u_timer (
        .clk      (clk),
        .por      (por),
        .rst      (rst),
        .wake     (wake),
        .pll_req  (pll_req),
        .cancel   (wr_main),
        .osc_len  (osc_len),
        .busy     (busy),
        .pll_done (pll_done)
    );

    always_comb begin
        rd_data             = '0;
        rd_data[RSV_HI_BIT] = 1'b1;
        rd_data[STAT_BIT]   = ctl.stat;
        rd_data[WS_HI_BIT:WS_LO_BIT] = ctl.ws;
        rd_data[RSV_LO_BIT] = 1'b1;
        rd_data[SEL_BIT]    = ctl.sel;
        rd_data[MULT_HI:0]  = ctl.mult;
    end

    assign use_pll  = !ctl.stat && !busy;
    assign pll_mult = ctl.mult;

    // R8: the machine clock stays on the main source during any wait
    assert_main_while_busy_R8: assert property (@(posedge clk) disable iff (por || rst)
        busy |-> !use_pll);

    // R3: reserved bits always read as one
    assert_reserved_ones_R3: assert property (@(posedge clk) disable iff (por)
        rd_data[RSV_HI_BIT] && rd_data[RSV_LO_BIT]);
endmodule

// File: tb/clksel_ctrl_test.sv
module clksel_ctrl_test;
    localparam int PLL_L = 4;
    localparam int POR_L = 6;
    localparam int W0 = 2, W1 = 3, W2 = 4, W3 = 5;

    logic       clk = 1'b0;
    logic       por = 1'b1;
    logic       rst = 1'b0;
    logic       wake = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic [7:0] rd_data;
    logic       use_pll;
    logic       busy;
    logic [1:0] pll_mult;

    int    checks = 0;
    int    errors = 0;
    int    cyc = 0;
    string phase = "R1";

    always #4 clk = ~clk;

    clksel_ctrl #(
        .PLL_LOG2 (PLL_L),
        .POR_LOG2 (POR_L),
        .WS0_LOG2 (W0),
        .WS1_LOG2 (W1),
        .WS2_LOG2 (W2),
        .WS3_LOG2 (W3)
    ) uut (
        .clk      (clk),
        .por      (por),
        .rst      (rst),
        .wake     (wake),
        .wr_en    (wr_en),
        .wr_data  (wr_data),
        .rd_data  (rd_data),
        .use_pll  (use_pll),
        .busy     (busy),
        .pll_mult (pll_mult)
    );

    task automatic chk(input string tag, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d (t=%0t)", tag, what, act, exp, $time);
        end
    endtask

    // behavioural reference: kind 0 idle, 1 power-on, 2 oscillator, 3 lock
    int m_sel, m_stat, m_ws, m_mult, m_kind, m_left;
    bit m_valid = 1'b0;

    function automatic int osc_len(input int c);
        case (c)
            0:       return 1 << W0;
            1:       return 1 << W1;
            2:       return 1 << W2;
            default: return 1 << W3;
        endcase
    endfunction

    always @(posedge clk) begin : mdl
        int nk, nl;
        bit req, can, done;
        if (por) begin
            m_sel = 1; m_stat = 1; m_ws = 3; m_mult = 0; m_kind = 1; m_left = 1 << POR_L;
        end else if (rst) begin
            m_sel = 1; m_stat = 1; m_mult = 0; m_kind = 0; m_left = 0;
        end else begin
            req  = (m_sel == 0) && (m_stat == 1);
            can  = wr_en && wr_data[2];
            done = (m_kind == 3) && (m_left == 1);
            nk = m_kind; nl = m_left;
            if (wake && m_kind != 1) begin
                nk = 2; nl = osc_len(m_ws);
            end else if (m_kind == 3 && can) begin
                nk = 0; nl = 0;
            end else if (m_kind != 0) begin
                if (m_left == 1) begin
                    if (m_kind != 3 && req && !can) begin nk = 3; nl = 1 << PLL_L; end
                    else begin nk = 0; nl = 0; end
                end else begin
                    nl = m_left - 1;
                end
            end else if (req && !can) begin
                nk = 3; nl = 1 << PLL_L;
            end
            if (can) m_stat = 1;
            else if (done) m_stat = 0;
            if (wr_en) begin
                m_sel = int'(wr_data[2]); m_ws = int'(wr_data[5:4]); m_mult = int'(wr_data[1:0]);
            end
            m_kind = nk; m_left = nl;
        end
        m_valid = 1'b1;
    end

    always @(negedge clk) begin
        if (m_valid) begin
            chk(phase, "rd_data", int'(rd_data), 128 + m_stat * 64 + m_ws * 16 + 8 + m_sel * 4 + m_mult);
            chk(phase, "busy", int'(busy), (m_kind != 0) ? 1 : 0);
            chk(phase, "use_pll", int'(use_pll), (m_stat == 0 && m_kind == 0) ? 1 : 0);
            chk(phase, "pll_mult", int'(pll_mult), m_mult);
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 20000) begin
            errors++;
            $display("FAIL R5 watchdog: actual %0d cycles expected below 20000", cyc);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [7:0] v);
        wr_en = 1'b1;
        wr_data = v;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic pulse_wake();
        wake = 1'b1;
        @(negedge clk);
        wake = 1'b0;
    endtask

    task automatic measure(output int n);
        n = 0;
        while (busy === 1'b1 && n < 5000) begin
            n++;
            @(negedge clk);
        end
    endtask

    initial begin
        int n;
        step(3);
        phase = "R1";
        chk("R1", "rd_data in reset", int'(rd_data), 'hFC);
        chk("R1", "pll_mult in reset", int'(pll_mult), 0);
        chk("R1", "use_pll in reset", int'(use_pll), 0);

        phase = "R5";
        por = 1'b0;
        measure(n);
        chk("R5", "power-on wait length", n, 1 << POR_L);

        phase = "R3";
        wr(8'h16);
        chk("R3", "status and reserved writes ignored", int'(rd_data), 'hDE);
        chk("R10", "multiplier code", int'(pll_mult), 2);

        phase = "R4";
        wr(8'h12);
        chk("R4", "no wait on write edge", int'(busy), 0);
        step(1);
        measure(n);
        chk("R4", "lock wait length", n, 1 << PLL_L);
        chk("R4", "use_pll after lock", int'(use_pll), 1);
        chk("R4", "status reads PLL", int'(rd_data), 'h9A);

        phase = "R7";
        wr(8'h16);
        chk("R7", "immediate return to main", int'(use_pll), 0);
        chk("R7", "status back to main", int'(rd_data), 'hDE);
        wr(8'h12);
        step(6);
        chk("R7", "lock wait running", int'(busy), 1);
        wr(8'h16);
        chk("R7", "cancel drops busy", int'(busy), 0);
        step(20);
        chk("R7", "no late switch", int'(use_pll), 0);
        chk("R7", "status stays main", int'(rd_data[6]), 1);

        phase = "R6";
        for (int c = 0; c < 4; c++) begin
            wr(8'(8'h04 | (c << 4)));
            pulse_wake();
            measure(n);
            chk("R6", $sformatf("oscillator wait code %0d", c), n, osc_len(c));
        end
        wr(8'h04);
        pulse_wake();
        step(2);
        pulse_wake();
        measure(n);
        chk("R6", "restarted oscillator wait", n, 1 << W0);

        phase = "R9";
        pulse_wake();
        wr(8'h34);
        measure(n);
        chk("R9", "running wait keeps old length", n + 1, 1 << W0);
        pulse_wake();
        measure(n);
        chk("R9", "next wait uses new code", n, 1 << W3);

        phase = "R8";
        wr(8'h00);
        step(1);
        measure(n);
        chk("R8", "on PLL before wake", int'(use_pll), 1);
        pulse_wake();
        chk("R8", "main while settling", int'(use_pll), 0);
        measure(n);
        chk("R8", "settle length on PLL", n, 1 << W0);
        chk("R8", "back on PLL", int'(use_pll), 1);

        phase = "R11";
        wr(8'h14);
        pulse_wake();
        wr(8'h10);
        measure(n);
        chk("R11", "chained wait with no gap", n + 1, (1 << W1) + (1 << PLL_L));
        chk("R11", "on PLL after chain", int'(use_pll), 1);

        phase = "R2";
        wr(8'h23);
        pulse_wake();
        step(3);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        chk("R2", "reset ends wait", int'(busy), 0);
        chk("R2", "reset keeps wait code", int'(rd_data), 'hEC);
        chk("R2", "reset clears multiplier", int'(pll_mult), 0);
        step(5);
        chk("R2", "no wait after reset", int'(busy), 0);

        phase = "R5";
        por = 1'b1;
        step(2);
        por = 1'b0;
        step(10);
        pulse_wake();
        measure(n);
        chk("R5", "wake ignored in power-on wait", n, (1 << POR_L) - 11);
        chk("R1", "power-on restores wait code", int'(rd_data), 'hFC);

        step(2);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule